// File: doc/BRIEF.md
# NOR Flash Command Sequencer and Write State Machine

This block models the control side of a parallel NOR flash: the command interface that decodes bus write cycles and the write state machine that carries out timed program and erase operations on a small internal byte array. The host uses active-low chip enable, write enable and output enable, all sampled on the block clock. A command takes effect only after a two-cycle unlock sequence followed by a command byte. Three command sequences are decoded: byte program, sector erase and whole-array erase.

While an operation runs, the ready output is held low. Reads return a status byte in place of array data. Bit 7 of the status byte carries a polling bit, and bit 6 flips on every read cycle. A running sector erase can be suspended. The array can then be read normally, and a resume command restarts the erase from the point where it stopped. An active-low hardware reset and an active-low write-protect input complete the control set.

Top module: `nor_cmd_engine`

## Requirements
- R1: While reset is asserted and after it is released, `ry_by` is 1 and the command decoder is in read mode, so a lone command byte written without an unlock does nothing.
- R2: The unlock writes are AAh at word address 555h and then 55h at 2AAh. A0h written at 555h after them selects program, and the next write gives the target address and data. The target cell becomes old AND data, so a program can only clear bits.
- R3: The block captures the write address when `we_n` falls and the write data when `we_n` rises, both while `ce_n` is low. Address or data values present at any other time have no effect.
- R4: `ry_by` is 0 for the whole of an operation. A program keeps it low for exactly PROG_CYCLES clock cycles. A sector erase keeps it low for twice the sector size in cycles, and a whole-array erase for twice the array size, excluding any suspended time.
- R5: During an operation, a read with `ce_n` and `oe_n` low returns a status byte. Bit 7 is the complement of bit 7 of the data being programmed; during an erase it is 0. Bit 6 takes a different value on each consecutive read. Bits 5 to 0 are 0.
- R6: While a program or a whole-array erase runs, every command write is ignored. This includes a complete new command sequence and the suspend code.
- R7: Sector erase is unlock, 80h at 555h, unlock again, then 30h at any address inside the sector. The sector is chosen by the top SECT_W address bits. The block first writes 00h to every cell of the sector and then FFh to every cell. Other sectors are left unchanged.
- R8: Whole-array erase is the same sequence as sector erase but ends with 10h at 555h, and it leaves every cell at FFh.
- R9: During a sector erase, a single write of B0h suspends the erase. `ry_by` then returns to 1 and reads return array data. While suspended, only a single write of 30h is honoured; it resumes the erase, which then completes normally.
- R10: Any write whose value or address differs from the next step of a sequence returns the decoder to read mode, and F0h is one such value. The unlock must then be given again from the start.
- R11: While `wp_n` is 0, a completed program or erase sequence and a resume write start nothing. `ry_by` stays 1 and the array is unchanged.
- R12: Asserting `rst_n` aborts any operation. `ry_by` goes to 1 at once, and after release the block accepts new commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Hardware reset, active low, asserted asynchronously and released synchronously |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; its falling edge captures the address and its rising edge captures the data |
| oe_n | input | 1 | Output enable, active low |
| wp_n | input | 1 | Write protect, active low; blocks every program and erase |
| addr | input | ADDR_W | Word address |
| wdata | input | 8 | Write data / command byte |
| rdata | output | 8 | Array data, or the status byte during an operation; 0 when not reading |
| ry_by | output | 1 | 1 when ready, 0 while an operation runs |

## Verification
Two functions can meet in one cycle: a suspend command can be decoded in the same cycle that the erase engine writes the last cell of its sector. The bench starts a series of sector erases and places the suspend write at offsets stepping across the final few cycles of each erase. After each suspend write it also sends a bare resume byte. That byte either resumes a suspended erase or, if the erase had already finished, is ignored because it has no unlock. The outcome is judged at the ports: `ry_by` must end high and every cell of the sector must read FFh, whichever of the two events won.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  localparam int unsigned DW = 8;

  localparam logic [DW-1:0] CODE_KEY1   = 8'hAA;
  localparam logic [DW-1:0] CODE_KEY2   = 8'h55;
  localparam logic [DW-1:0] CODE_PROG   = 8'hA0;
  localparam logic [DW-1:0] CODE_ERASE  = 8'h80;
  localparam logic [DW-1:0] CODE_SECT   = 8'h30;
  localparam logic [DW-1:0] CODE_CHIP   = 8'h10;
  localparam logic [DW-1:0] CODE_HOLD   = 8'hB0;
  localparam logic [DW-1:0] CODE_RESUME = 8'h30;

  localparam logic [11:0] KEY1_ADR = 12'h555;
  localparam logic [11:0] KEY2_ADR = 12'h2AA;

  typedef enum logic [2:0] {
    SQ_READ, SQ_KEY1, SQ_KEY2, SQ_PGM, SQ_ER1, SQ_ER2, SQ_ER3
  } seq_st_e;

  typedef enum logic [1:0] {
    WS_IDLE, WS_PROG, WS_ERASE, WS_HOLD
  } wsm_st_e;

endpackage

// File: rtl/nor_bus_capture.sv
module nor_bus_capture #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ce_n,
  input  logic                       we_n,
  input  logic                       oe_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [nor_cmd_pkg::DW-1:0] wdata,
  output logic                       cmd_vld,
  output logic [ADDR_W-1:0]          cmd_addr,
  output logic [nor_cmd_pkg::DW-1:0] cmd_data,
  output logic                       rd_start
);
  import nor_cmd_pkg::*;

  logic          we_q, oe_q;
  logic          we_fall, we_rise;
  logic [DW-1:0] data_q;

  assign we_fall  = !ce_n && we_q && !we_n;
  assign we_rise  = !ce_n && !we_q && we_n;
  assign rd_start = !ce_n && oe_q && !oe_n && we_n;
  assign cmd_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      cmd_vld <= 1'b0;
    end else begin
      we_q    <= we_n;
      oe_q    <= oe_n;
      cmd_vld <= we_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_addr <= '0;
    end else if (we_fall) begin
      cmd_addr <= addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (we_rise) begin
      data_q <= wdata;
    end
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_vld,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic [nor_cmd_pkg::DW-1:0] cmd_data,
  input  logic                       busy,
  input  logic                       sec_run,
  input  logic                       held,
  output logic                       prog_go,
  output logic                       sec_go,
  output logic                       chip_go,
  output logic                       hold_go,
  output logic                       resume_go,
  output logic [ADDR_W-1:0]          op_addr,
  output logic [nor_cmd_pkg::DW-1:0] op_data
);
  import nor_cmd_pkg::*;

  localparam logic [ADDR_W-1:0] ADR_K1 = ADDR_W'(KEY1_ADR);
  localparam logic [ADDR_W-1:0] ADR_K2 = ADDR_W'(KEY2_ADR);

  seq_st_e           st_q, st_n;
  logic              prog_n, sec_n, chip_n, hold_n, resume_n;
  logic [ADDR_W-1:0] opa_n;
  logic [DW-1:0]     opd_n;
  logic              launch, at_k1, at_k2;

  assign launch = prog_go || sec_go || chip_go || hold_go || resume_go;
  assign at_k1  = (cmd_addr == ADR_K1);
  assign at_k2  = (cmd_addr == ADR_K2);

  always_comb begin
    st_n     = st_q;
    prog_n   = 1'b0;
    sec_n    = 1'b0;
    chip_n   = 1'b0;
    hold_n   = 1'b0;
    resume_n = 1'b0;
    opa_n    = op_addr;
    opd_n    = op_data;
    if (cmd_vld) begin
      if (busy || held || launch) begin
        st_n = SQ_READ;
        if (!launch && sec_run && cmd_data == CODE_HOLD)  hold_n   = 1'b1;
        if (!launch && held && cmd_data == CODE_RESUME)   resume_n = 1'b1;
      end else begin
        st_n = SQ_READ;
        unique case (st_q)
          SQ_READ: if (at_k1 && cmd_data == CODE_KEY1) st_n = SQ_KEY1;
          SQ_KEY1: if (at_k2 && cmd_data == CODE_KEY2) st_n = SQ_KEY2;
          SQ_KEY2: begin
            if (at_k1 && cmd_data == CODE_PROG)  st_n = SQ_PGM;
            if (at_k1 && cmd_data == CODE_ERASE) st_n = SQ_ER1;
          end
          SQ_PGM: begin
            prog_n = 1'b1;
            opa_n  = cmd_addr;
            opd_n  = cmd_data;
          end
          SQ_ER1: if (at_k1 && cmd_data == CODE_KEY1) st_n = SQ_ER2;
          SQ_ER2: if (at_k2 && cmd_data == CODE_KEY2) st_n = SQ_ER3;
          SQ_ER3: begin
            if (cmd_data == CODE_SECT) begin
              sec_n = 1'b1;
              opa_n = cmd_addr;
            end else if (at_k1 && cmd_data == CODE_CHIP) begin
              chip_n = 1'b1;
            end
          end
          default: st_n = SQ_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_READ;
      prog_go   <= 1'b0;
      sec_go    <= 1'b0;
      chip_go   <= 1'b0;
      hold_go   <= 1'b0;
      resume_go <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
    end else begin
      st_q      <= st_n;
      prog_go   <= prog_n;
      sec_go    <= sec_n;
      chip_go   <= chip_n;
      hold_go   <= hold_n;
      resume_go <= resume_n;
      op_addr   <= opa_n;
      op_data   <= opd_n;
    end
  end

endmodule

// File: rtl/nor_wsm.sv
module nor_wsm #(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned SECT_W      = 2,
  parameter int unsigned PROG_CYCLES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wp_n,
  input  logic                       prog_go,
  input  logic                       sec_go,
  input  logic                       chip_go,
  input  logic                       hold_go,
  input  logic                       resume_go,
  input  logic [ADDR_W-1:0]          op_addr,
  input  logic [nor_cmd_pkg::DW-1:0] op_data,
  input  logic                       rd_start,
  input  logic [nor_cmd_pkg::DW-1:0] mem_rdata,
  output logic                       busy,
  output logic                       sec_run,
  output logic                       held,
  output logic                       op_prog,
  output logic [nor_cmd_pkg::DW-1:0] status,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [nor_cmd_pkg::DW-1:0] mem_wdata
);
  import nor_cmd_pkg::*;

  localparam int unsigned OFF_W = ADDR_W - SECT_W;
  localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1);

  wsm_st_e           st_q, st_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n, sect_base;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DW-1:0]     dat_q, dat_n;
  logic              pre_q, pre_n, chip_q, chip_n, tog_q, last_cell;

  assign sect_base = {ptr_q[ADDR_W-1 -: SECT_W], {OFF_W{1'b0}}};
  assign last_cell = chip_q ? (&ptr_q) : (&ptr_q[OFF_W-1:0]);
  assign busy      = (st_q == WS_PROG) || (st_q == WS_ERASE);
  assign sec_run   = (st_q == WS_ERASE) && !chip_q;
  assign held      = (st_q == WS_HOLD);
  assign op_prog   = (st_q == WS_PROG);
  assign mem_addr  = ptr_q;
  assign status    = {(op_prog ? ~dat_q[DW-1] : 1'b0), tog_q, {(DW-2){1'b0}}};

  always_comb begin
    st_n      = st_q;
    ptr_n     = ptr_q;
    cnt_n     = cnt_q;
    dat_n     = dat_q;
    pre_n     = pre_q;
    chip_n    = chip_q;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (st_q)
      WS_IDLE: begin
        if (wp_n) begin
          if (prog_go) begin
            st_n  = WS_PROG;
            ptr_n = op_addr;
            dat_n = op_data;
            cnt_n = CNT_W'(PROG_CYCLES - 1);
          end else if (sec_go) begin
            st_n   = WS_ERASE;
            ptr_n  = {op_addr[ADDR_W-1 -: SECT_W], {OFF_W{1'b0}}};
            chip_n = 1'b0;
            pre_n  = 1'b1;
          end else if (chip_go) begin
            st_n   = WS_ERASE;
            ptr_n  = '0;
            chip_n = 1'b1;
            pre_n  = 1'b1;
          end
        end
      end
      WS_PROG: begin
        if (cnt_q == '0) begin
          mem_we    = 1'b1;
          mem_wdata = mem_rdata & dat_q;
          st_n      = WS_IDLE;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
      WS_ERASE: begin
        if (hold_go && !chip_q) begin
          st_n = WS_HOLD;
        end else begin
          mem_we    = 1'b1;
          mem_wdata = pre_q ? '0 : '1;
          if (last_cell) begin
            if (pre_q) begin
              pre_n = 1'b0;
              ptr_n = chip_q ? '0 : sect_base;
            end else begin
              st_n = WS_IDLE;
            end
          end else begin
            ptr_n = ptr_q + ADDR_W'(1);
          end
        end
      end
      WS_HOLD: begin
        if (resume_go && wp_n) st_n = WS_ERASE;
      end
      default: st_n = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      ptr_q  <= '0;
      cnt_q  <= '0;
      dat_q  <= '0;
      pre_q  <= 1'b0;
      chip_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      ptr_q  <= ptr_n;
      cnt_q  <= cnt_n;
      dat_q  <= dat_n;
      pre_q  <= pre_n;
      chip_q <= chip_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (rd_start && busy) begin
      tog_q <= ~tog_q;
    end
  end

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine #(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned SECT_W      = 2,
  parameter int unsigned PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              ry_by
);
  import nor_cmd_pkg::*;

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic              rst_s0, rst_sync_n;
  logic              cmd_vld, rd_start;
  logic [ADDR_W-1:0] cmd_addr, op_addr, mem_addr;
  logic [DW-1:0]     cmd_data, op_data, mem_wdata, status;
  logic              prog_go, sec_go, chip_go, hold_go, resume_go;
  logic              busy, sec_run, held, op_prog, mem_we, rd_en;
  logic [DW-1:0]     mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  nor_bus_capture #(.ADDR_W(ADDR_W)) bus_i (
    .clk(clk), .rst_n(rst_sync_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .cmd_vld(cmd_vld), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_start(rd_start)
  );

  nor_cmd_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_sync_n), .cmd_vld(cmd_vld), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .busy(busy), .sec_run(sec_run), .held(held),
    .prog_go(prog_go), .sec_go(sec_go), .chip_go(chip_go), .hold_go(hold_go),
    .resume_go(resume_go), .op_addr(op_addr), .op_data(op_data)
  );

  nor_wsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYCLES(PROG_CYCLES)) wsm_i (
    .clk(clk), .rst_n(rst_sync_n), .wp_n(wp_n), .prog_go(prog_go),
    .sec_go(sec_go), .chip_go(chip_go), .hold_go(hold_go),
    .resume_go(resume_go), .op_addr(op_addr), .op_data(op_data),
    .rd_start(rd_start), .mem_rdata(mem[mem_addr]), .busy(busy),
    .sec_run(sec_run), .held(held), .op_prog(op_prog), .status(status),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  assign rd_en = !ce_n && !oe_n && we_n;
  assign ry_by = !busy;

  always_comb begin
    if (!rd_en)    rdata = '0;
    else if (busy) rdata = status;
    else           rdata = mem[addr];
  end

endmodule

// File: rtl/nor_cmd_engine_chk.sv
module nor_cmd_engine_chk #(
  parameter int unsigned PROG_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       wp_n,
  input logic       ry_by,
  input logic [7:0] rdata,
  input logic       op_prog,
  input logic       prog_go,
  input logic       sec_go,
  input logic       chip_go,
  input logic       hold_go
);

  logic        prog_run, prog_run_q;
  int unsigned run_cnt;

  assign prog_run = !ry_by && op_prog;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prog_run_q <= 1'b0;
      run_cnt    <= 0;
    end else begin
      prog_run_q <= prog_run;
      run_cnt    <= prog_run ? run_cnt + 1 : 0;
    end
  end

  a_r1_ready_out_of_reset: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> ry_by);

  a_r4_prog_length: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prog_run_q && !prog_run) |-> (run_cnt == PROG_CYCLES));

  a_r5_status_low_bits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ce_n && !oe_n && we_n && !ry_by) |-> (rdata[5:0] == 6'd0));

  a_r6_no_launch_when_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ry_by |-> !(prog_go || sec_go || chip_go));

  a_r9_hold_frees_ready: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_go |=> ry_by);

  a_r11_protect_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ry_by && !wp_n) |=> ry_by);

endmodule

bind nor_cmd_engine nor_cmd_engine_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .wp_n(wp_n), .ry_by(ry_by), .rdata(rdata), .op_prog(op_prog),
  .prog_go(prog_go), .sec_go(sec_go), .chip_go(chip_go), .hold_go(hold_go)
);

// File: tb/nor_cmd_engine_tb_top.sv
module nor_cmd_engine_tb_top;

  localparam int unsigned AW    = 11;
  localparam int unsigned SW    = 2;
  localparam int unsigned PC    = 40;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned SECT  = 1 << (AW - SW);

  logic          clk = 1'b0;
  logic          rst_n, ce_n, we_n, oe_n, wp_n;
  logic [AW-1:0] addr;
  logic [7:0]    wdata, rdata;
  logic          ry_by;

  int   errors = 0;
  int   checks = 0;
  bit   done   = 1'b0;
  logic [7:0] shadow [DEPTH];

  always #10 clk = ~clk;

  nor_cmd_engine #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wp_n(wp_n), .addr(addr), .wdata(wdata), .rdata(rdata), .ry_by(ry_by)
  );

  function automatic logic [7:0] prog_result(input logic [7:0] old_v, input logic [7:0] d);
    return old_v & d;
  endfunction

  function automatic logic [AW-1:0] sect_addr(input int s, input int off);
    return AW'(s * SECT + off);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; addr = a; wdata = 8'($urandom);
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); addr = AW'($urandom); wdata = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk); d = rdata; oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic unlock();
    bus_write(AW'(12'h555), 8'hAA);
    bus_write(AW'(12'h2AA), 8'h55);
  endtask

  task automatic do_program(input logic [AW-1:0] a, input logic [7:0] d);
    unlock();
    bus_write(AW'(12'h555), 8'hA0);
    bus_write(a, d);
    settle();
  endtask

  task automatic do_erase(input logic [7:0] last, input logic [AW-1:0] a);
    unlock();
    bus_write(AW'(12'h555), 8'h80);
    unlock();
    bus_write(a, last);
    settle();
  endtask

  task automatic wait_ready(input int limit, output int cycles);
    cycles = 0;
    while (!ry_by && cycles < limit) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic compare_range(input int lo, input int hi, input string req);
    logic [7:0] v;
    int bad = 0;
    int bad_a = 0;
    logic [7:0] bad_v = 0;
    for (int i = lo; i < hi; i++) begin
      bus_read(AW'(i), v);
      if (v !== shadow[i] && bad == 0) begin
        bad = 1; bad_a = i; bad_v = v;
      end
    end
    check(bad == 0, req, bad_v, shadow[bad_a]);
  endtask

  initial begin
    logic [7:0] v, v2;
    int cyc;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; wp_n = 1'b1;
    addr = '0; wdata = '0;
    v = $urandom(32'd7345);
    repeat (4) @(negedge clk);
    check(ry_by === 1'b1, "R1 ready in reset", ry_by, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ry_by === 1'b1, "R1 ready after reset", ry_by, 1);
    bus_write(AW'(12'h555), 8'hA0);
    bus_write(AW'(12'h010), 8'h00);
    settle();
    check(ry_by === 1'b1, "R1 bare command ignored", ry_by, 1);

    // R8: whole-array erase, suspend ignored during it (R6)
    do_erase(8'h10, AW'(12'h555));
    check(ry_by === 1'b0, "R4 busy on array erase", ry_by, 0);
    bus_write(AW'(12'h000), 8'hB0);
    settle();
    check(ry_by === 1'b0, "R6 suspend ignored in array erase", ry_by, 0);
    wait_ready(3 * DEPTH, cyc);
    check(cyc > 2 * DEPTH - 16 && cyc < 2 * DEPTH + 4, "R4 array erase length", cyc, 2 * DEPTH);
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
    compare_range(0, DEPTH, "R8 array all FF");

    // R2, R5: directed program with status reads
    do_program(AW'(12'h123), 8'h5A);
    check(ry_by === 1'b0, "R4 busy on program", ry_by, 0);
    bus_read(AW'(12'h123), v);
    bus_read(AW'(12'h123), v2);
    check(v[7] === 1'b1, "R5 polling bit program", v[7], 1);
    check(v[6] !== v2[6], "R5 toggle bit", v2[6], ~v[6]);
    check(v[5:0] === 6'd0, "R5 low status bits", v[5:0], 0);
    // R6: full sequence during program is dropped
    do_program(AW'(12'h700), 8'h00);
    wait_ready(4 * PC, cyc);
    check(ry_by === 1'b1, "R4 program completes", ry_by, 1);
    shadow[12'h123] = prog_result(shadow[12'h123], 8'h5A);
    bus_read(AW'(12'h700), v);
    check(v === 8'hFF, "R6 command during program ignored", v, 8'hFF);
    bus_read(AW'(12'h123), v);
    check(v === 8'h5A, "R2 programmed value", v, 8'h5A);
    do_program(AW'(12'h123), 8'hF0);
    wait_ready(4 * PC, cyc);
    bus_read(AW'(12'h123), v);
    check(v === 8'h50, "R2 program only clears bits", v, 8'h50);
    shadow[12'h123] = 8'h50;

    // R10: broken sequences
    unlock();
    bus_write(AW'(12'h555), 8'h77);
    bus_write(AW'(12'h555), 8'hA0);
    bus_write(AW'(12'h200), 8'h00);
    settle();
    check(ry_by === 1'b1, "R10 wrong code aborts", ry_by, 1);
    bus_write(AW'(12'h555), 8'hAA);
    bus_write(AW'(12'h2AB), 8'h55);
    bus_write(AW'(12'h555), 8'hA0);
    bus_write(AW'(12'h201), 8'h00);
    unlock();
    bus_write(AW'(12'h555), 8'hF0);
    bus_write(AW'(12'h555), 8'hA0);
    bus_write(AW'(12'h202), 8'h00);
    settle();
    bus_read(AW'(12'h200), v);
    bus_read(AW'(12'h201), v2);
    check(v === 8'hFF && v2 === 8'hFF, "R10 no program after bad sequence", {v, v2}, 16'hFFFF);
    bus_read(AW'(12'h202), v);
    check(v === 8'hFF, "R10 reset code returns to read", v, 8'hFF);

    // R3 + random programs
    for (int n = 0; n < 40; n++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = AW'($urandom);
      d = 8'($urandom);
      do_program(a, d);
      wait_ready(4 * PC, cyc);
      shadow[a] = prog_result(shadow[a], d);
    end
    compare_range(0, DEPTH, "R3 random programs with skewed bus values");

    // R7: sector erase of sector 1
    do_erase(8'h30, sect_addr(1, 77));
    bus_read(AW'(12'h000), v);
    check(v[7] === 1'b0 && v[5:0] === 6'd0, "R5 erase status", v, 0);
    wait_ready(4 * SECT, cyc);
    check(cyc > 2 * SECT - 16 && cyc < 2 * SECT + 4, "R4 sector erase length", cyc, 2 * SECT);
    for (int i = SECT; i < 2 * SECT; i++) shadow[i] = 8'hFF;
    compare_range(0, DEPTH, "R7 only sector 1 erased");

    // R9: suspend, read, ignored program, resume
    for (int i = 2 * SECT; i < 2 * SECT + 8; i++) begin
      do_program(AW'(i), 8'h00);
      wait_ready(4 * PC, cyc);
      shadow[i] = 8'h00;
    end
    do_erase(8'h30, sect_addr(2, 5));
    repeat (100) @(negedge clk);
    bus_write(AW'(12'h3FF), 8'hB0);
    settle();
    check(ry_by === 1'b1, "R9 suspend frees ready", ry_by, 1);
    bus_read(AW'(12'h123), v);
    check(v === shadow[12'h123], "R9 array read while suspended", v, shadow[12'h123]);
    do_program(sect_addr(0, 9), 8'h00);
    check(ry_by === 1'b1, "R9 program ignored while suspended", ry_by, 1);
    bus_read(sect_addr(0, 9), v);
    check(v === shadow[9], "R9 suspended target unchanged", v, shadow[9]);
    bus_write(AW'(12'h000), 8'h30);
    settle();
    check(ry_by === 1'b0, "R9 resume restarts erase", ry_by, 0);
    wait_ready(4 * SECT, cyc);
    for (int i = 2 * SECT; i < 3 * SECT; i++) shadow[i] = 8'hFF;
    compare_range(2 * SECT, 3 * SECT, "R9 sector erased after resume");

    // Same-cycle sweep: suspend near end of erase
    for (int k = 0; k < 8; k++) begin
      do_erase(8'h30, sect_addr(3, 1));
      repeat (2 * SECT - 12 + k) @(negedge clk);
      bus_write(AW'(12'h000), 8'hB0);
      settle();
      bus_write(AW'(12'h000), 8'h30);
      settle();
      wait_ready(4 * SECT, cyc);
      check(ry_by === 1'b1, "R9 suspend at erase end", ry_by, 1);
    end
    for (int i = 3 * SECT; i < 4 * SECT; i++) shadow[i] = 8'hFF;
    compare_range(3 * SECT, 4 * SECT, "R9 sector clean after end sweep");

    // R11: write protect
    wp_n = 1'b0;
    do_program(sect_addr(3, 3), 8'h00);
    check(ry_by === 1'b1, "R11 program blocked", ry_by, 1);
    do_erase(8'h30, sect_addr(0, 0));
    check(ry_by === 1'b1, "R11 erase blocked", ry_by, 1);
    wp_n = 1'b1;
    compare_range(0, DEPTH, "R11 array unchanged");

    // R12: hardware reset aborts erase
    do_erase(8'h10, AW'(12'h555));
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(ry_by === 1'b1, "R12 reset aborts", ry_by, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_erase(8'h10, AW'(12'h555));
    check(ry_by === 1'b0, "R12 commands after reset", ry_by, 0);
    wait_ready(3 * DEPTH, cyc);
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
    compare_range(0, DEPTH, "R12 array erased after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule